// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This unit lives in the decode stage of a five-stage in-order pipeline. It looks at the instruction now in execute and the instruction now in decode, and stalls when the first is a load whose destination register is a source of the second. Forwarding cannot cover that case, because the loaded value is not ready until the memory stage finishes.

On a hazard, in the same cycle, it drops the program-counter write enable and the fetch/decode register write enable. The instruction in decode and the instruction in fetch therefore both stay where they are. It also raises a select that zeroes every control bit entering the decode/execute register, which puts a no-op bubble into execute. The next cycle the load has moved to memory, and the held instruction goes ahead with its value forwarded. Everything behind the load is delayed by exactly one cycle.

Register zero is a constant, so a load that names it as destination never causes a stall. A one-bit history register blocks a second stall in the cycle right after a stall. This keeps each stall to a single cycle, even if the execute inputs still show the same load.

Top module: `lhz_load_use_unit`

## Requirements
- R1: After reset, with no load in execute, `pc_we` = 1, `ifid_we` = 1 and `ctl_zero` = 0.
- R2: When `ex_mem_read` = 1, `ex_rd` is nonzero and `ex_rd` equals `id_rs1`, then in that same cycle `pc_we` = 0, `ifid_we` = 0 and `ctl_zero` = 1, unless the previous cycle stalled.
- R3: The same stall happens when `ex_rd` is nonzero and equals `id_rs2`.
- R4: There is no stall when `ex_mem_read` = 0, or when `ex_rd` matches neither source.
- R5: When `ex_rd` = 0 there is never a stall, even if both sources are also 0.
- R6: In the cycle right after a stall cycle there is never a stall, even if the inputs are unchanged. Each stall therefore lasts exactly one cycle.
- R7: The outputs always agree: `pc_we` equals `ifid_we`, and both are the inverse of `ctl_zero`.
- R8: In the modelled pipeline, a load followed directly by a dependent instruction adds exactly one cycle to the run. This holds when the dependence is through either source, and also when the dependent instruction is a second load that uses the first load's result as its address base.
- R9: In the modelled pipeline, a load followed by an unrelated instruction, a load whose result is used two instructions later, and two independent loads in a row all add no cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the stall history |
| ex_mem_read | input | 1 | Memory-read flag of the instruction in execute |
| ex_rd | input | REG_W | Destination register number of the instruction in execute |
| id_rs1 | input | REG_W | First source register number of the instruction in decode |
| id_rs2 | input | REG_W | Second source register number of the instruction in decode |
| pc_we | output | 1 | Program-counter write enable; 0 holds the PC |
| ifid_we | output | 1 | Fetch/decode register write enable; 0 holds it |
| ctl_zero | output | 1 | 1 selects all-zero control bits into the decode/execute register |

## Verification
The three outputs are combinational from the current inputs plus one history bit. The bench therefore drives each vector just after a falling edge and samples the outputs 1 ns later, inside the same cycle and before the next rising edge. The one-cycle limit (R6) depends on the history bit, which updates at the rising edge. It is checked by holding the inputs across one rising edge, then another, and sampling after each. The pipeline-level checks (R8, R9) count rising edges from the release of the model's reset until the last instruction has entered execute. A run of N instructions with S stalls must take exactly N+1+S edges.

// File: rtl/lhz_pkg.sv
package lhz_pkg;
  localparam int unsigned LHZ_REG_W_DEFAULT = 5;
  localparam int unsigned LHZ_NUM_SRC       = 2;

  typedef enum logic {
    HZ_CLEAR = 1'b0,
    HZ_STALL = 1'b1
  } hz_state_e;
endpackage

// File: rtl/lhz_src_match.sv
module lhz_src_match #(
  parameter int unsigned REG_W       = 5,
  parameter bit          IGNORE_ZERO = 1'b1
) (
  input  logic [REG_W-1:0] tgt,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  logic tgt_live;

  generate
    if (IGNORE_ZERO) begin : g_zero_const
      assign tgt_live = |tgt;
    end else begin : g_zero_plain
      assign tgt_live = 1'b1;
    end
  endgenerate

  assign hit = tgt_live && (tgt == src);
endmodule

// File: rtl/lhz_stall_ctrl.sv
module lhz_stall_ctrl
  import lhz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic stall
);
  hz_state_e state_q;

  assign stall = req && (state_q == HZ_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) state_q <= HZ_CLEAR;
    else     state_q <= stall ? HZ_STALL : HZ_CLEAR;
  end
endmodule

// File: rtl/lhz_load_use_unit.sv
module lhz_load_use_unit
  import lhz_pkg::*;
#(
  parameter int unsigned REG_W       = LHZ_REG_W_DEFAULT,
  parameter bit          IGNORE_ZERO = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_rd,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ctl_zero
);
  localparam int unsigned NSRC = LHZ_NUM_SRC;

  logic [REG_W-1:0] src_vec [NSRC];
  logic [NSRC-1:0]  src_hit;
  logic             hz_req;
  logic             stall;

  assign src_vec[0] = id_rs1;
  assign src_vec[1] = id_rs2;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    lhz_src_match #(.REG_W(REG_W), .IGNORE_ZERO(IGNORE_ZERO)) u_match (
      .tgt (ex_rd),
      .src (src_vec[gi]),
      .hit (src_hit[gi])
    );
  end

  assign hz_req = ex_mem_read && (|src_hit);

  lhz_stall_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .req   (hz_req),
    .stall (stall)
  );

  assign pc_we    = ~stall;
  assign ifid_we  = ~stall;
  assign ctl_zero = stall;
endmodule

// File: rtl/lhz_load_use_chk.sv
module lhz_load_use_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ex_mem_read,
  input logic [REG_W-1:0] ex_rd,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             ctl_zero
);
  logic prev_bubble;

  always_ff @(posedge clk) begin
    if (rst) prev_bubble <= 1'b0;
    else     prev_bubble <= ctl_zero;
  end

  p_rs1_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (ex_mem_read && ex_rd != '0 && ex_rd == id_rs1 && !prev_bubble) |-> (ctl_zero && !pc_we));

  p_rs2_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_mem_read && ex_rd != '0 && ex_rd == id_rs2 && !prev_bubble) |-> (ctl_zero && !ifid_we));

  p_no_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!ex_mem_read) |-> (!ctl_zero && pc_we));

  p_zero_target_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_rd == '0) |-> !ctl_zero);

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_zero |=> !ctl_zero);

  p_outputs_agree_r7: assert property (@(posedge clk) disable iff (rst)
    (pc_we == ifid_we) && (pc_we != ctl_zero));
endmodule

bind lhz_load_use_unit lhz_load_use_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ex_mem_read (ex_mem_read),
  .ex_rd       (ex_rd),
  .id_rs1      (id_rs1),
  .id_rs2      (id_rs2),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .ctl_zero    (ctl_zero)
);

// File: tb/lhz_load_use_unit_tb.sv
`timescale 1ns/1ps
module lhz_load_use_unit_tb;
  localparam int W = 5;
  localparam int NV = 8;
  localparam int PMAX = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic         mode_pipe = 1'b0;
  logic         v_mr = 1'b0;
  logic [W-1:0] v_rd = '0, v_rs1 = '0, v_rs2 = '0;

  logic         mrst = 1'b1;
  logic         p_ld  [PMAX];
  logic [W-1:0] p_rd  [PMAX];
  logic [W-1:0] p_rs1 [PMAX];
  logic [W-1:0] p_rs2 [PMAX];
  int           p_n = 0;
  int           pc;
  logic         ifid_v, idex_v, idex_ld;
  logic [W-1:0] ifid_rs1, ifid_rs2, idex_rd;
  int           ex_cnt;

  logic         d_mr;
  logic [W-1:0] d_rd, d_rs1, d_rs2;
  logic         pc_we, ifid_we, ctl_zero;

  assign d_mr  = mode_pipe ? (idex_v && idex_ld) : v_mr;
  assign d_rd  = mode_pipe ? idex_rd : v_rd;
  assign d_rs1 = mode_pipe ? (ifid_v ? ifid_rs1 : '0) : v_rs1;
  assign d_rs2 = mode_pipe ? (ifid_v ? ifid_rs2 : '0) : v_rs2;

  lhz_load_use_unit #(.REG_W(W)) u_dut (
    .clk(clk), .rst(rst), .ex_mem_read(d_mr), .ex_rd(d_rd),
    .id_rs1(d_rs1), .id_rs2(d_rs2),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctl_zero(ctl_zero)
  );

  // Pipeline register model driven by the unit's outputs
  always @(posedge clk) begin
    if (mrst) begin
      pc <= 0; ifid_v <= 1'b0; idex_v <= 1'b0; idex_ld <= 1'b0;
      ifid_rs1 <= '0; ifid_rs2 <= '0; idex_rd <= '0; ex_cnt <= 0;
    end else begin
      if (pc_we) pc <= pc + 1;
      if (ifid_we) begin
        ifid_v <= (pc < p_n);
        ifid_rs1 <= (pc < p_n) ? p_rs1[pc] : '0;
        ifid_rs2 <= (pc < p_n) ? p_rs2[pc] : '0;
      end
      if (ctl_zero) begin
        idex_v <= 1'b0; idex_ld <= 1'b0; idex_rd <= '0;
      end else begin
        idex_v  <= ifid_v;
        idex_ld <= ifid_v && p_ld[pc-1];
        idex_rd <= ifid_v ? p_rd[pc-1] : '0;
        if (ifid_v) ex_cnt <= ex_cnt + 1;
      end
    end
  end

  // vector: {mr, rd, rs1, rs2, exp_stall, req_code}
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 5'd5,  5'd5,  5'd0,  1'b0, 4'd4},  // R4 no load
    {1'b1, 5'd5,  5'd5,  5'd7,  1'b1, 4'd2},  // R2 rs1 hit
    {1'b1, 5'd9,  5'd3,  5'd9,  1'b1, 4'd3},  // R3 rs2 hit
    {1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 4'd5},  // R5 zero target
    {1'b1, 5'd4,  5'd3,  5'd6,  1'b0, 4'd4},  // R4 unrelated
    {1'b1, 5'd31, 5'd31, 5'd31, 1'b1, 4'd2},  // R2 both hit
    {1'b0, 5'd12, 5'd12, 5'd12, 1'b0, 4'd4},  // R4 not a load
    {1'b1, 5'd1,  5'd2,  5'd3,  1'b0, 4'd4}   // R4 unrelated
  };

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic exp_stall);
    chk(tag, ctl_zero, exp_stall);
    chk(tag, pc_we, !exp_stall);
    chk({tag, "/R7"}, ifid_we, !exp_stall);
  endtask

  task automatic put(input int i, input logic ld, input int rd, input int a, input int b);
    p_ld[i] = ld; p_rd[i] = W'(rd); p_rs1[i] = W'(a); p_rs2[i] = W'(b);
  endtask

  task automatic run_prog(input string tag, input int n, input int stalls);
    int edges;
    edges = 0;
    @(negedge clk); p_n = n; mrst = 1'b1;
    @(posedge clk); @(negedge clk); mrst = 1'b0;
    while (edges < 100) begin
      @(posedge clk); edges++;
      #1;
      if (ex_cnt == n) break;
    end
    chk(tag, edges, n + 1 + stalls);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < PMAX; i++) put(i, 1'b0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 chk_out("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {v_mr, v_rd, v_rs1, v_rs2} = VEC[i][20:5];
      #1 chk_out(tag_of(VEC[i][3:0]), VEC[i][4]);
      @(negedge clk); v_mr = 1'b0;
    end

    // R6: held hazard stalls once, then releases, then may stall again
    @(negedge clk); v_mr = 1'b1; v_rd = 5'd8; v_rs1 = 5'd8; v_rs2 = 5'd1;
    #1 chk_out("R6", 1'b1);
    @(negedge clk); #1 chk_out("R6", 1'b0);
    @(negedge clk); #1 chk_out("R6", 1'b1);
    @(negedge clk); v_mr = 1'b0;

    mode_pipe = 1'b1;
    // R8: load then dependent (rs1)
    put(0, 1, 5, 1, 0); put(1, 0, 6, 5, 1); put(2, 0, 7, 2, 3);
    run_prog("R8", 3, 1);
    // R9: load, unrelated, then use
    put(0, 1, 5, 1, 0); put(1, 0, 6, 1, 2); put(2, 0, 7, 5, 5);
    run_prog("R9", 3, 0);
    // R8: two loads, second uses first as base
    put(0, 1, 5, 1, 0); put(1, 1, 6, 5, 0);
    run_prog("R8", 2, 1);
    // R9: two independent loads
    put(0, 1, 5, 1, 0); put(1, 1, 6, 2, 0);
    run_prog("R9", 2, 0);
    // R5: load into register zero then use of zero
    put(0, 1, 0, 1, 0); put(1, 0, 6, 0, 0);
    run_prog("R5", 2, 0);
    // R8: two load-use pairs, via rs2 then rs1
    put(0, 1, 3, 1, 0); put(1, 0, 4, 1, 3); put(2, 1, 8, 2, 0); put(3, 0, 9, 8, 4);
    run_prog("R8", 4, 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule